// File: doc/BRIEF.md
# Shadow Stack Push / Pop-Check Unit

This execution unit protects return addresses by keeping a second, hardware-owned copy of each saved link value. It holds the shadow stack pointer and carries out three operations handed to it already decoded. A push lowers the pointer by one entry and stores the link register at the new top. A pop-and-check reads the top entry, compares it with the named link register and raises the pointer on a match. A pointer read copies the pointer into a destination register. The stack grows toward lower addresses, and the pointer always names the most recently stored entry.

Memory traffic goes through a single request/response port. The unit works on one operation at a time and shows that it is busy from acceptance until the memory response has been taken. When the feature is switched off, the operations fall back to no-op behaviour. Operations that name an unsupported register are rejected. Accesses made under untranslated addressing below machine privilege are refused with access faults. A pointer update is committed only when the operation completes without a fault or a check failure.

Top module: `shadow_stack_unit`

## Requirements
- R1: After reset the pointer equals the parameter RESET_PTR, busy_o and mem_req_valid_o are low, and no done_o, wb_valid_o or exc_valid_o pulse is present.
- R2: A push (op_kind_i = 0) issues a write request at the pointer minus the entry size, where the entry size is 8 bytes when wide_i = 1 and 4 bytes when wide_i = 0. The request carries the source value. The lowered pointer is committed in the same cycle as done_o, after the memory response.
- R3: A pop-and-check (op_kind_i = 1) issues a read request at the current pointer. When the returned entry equals the named register value, the pointer rises by the entry size at done_o.
- R4: On a pop-and-check mismatch the unit pulses exc_valid_o with exc_cause_o = 3 (software check), and the pointer keeps its old value. When wide_i = 0, only the low 32 bits are compared, and a push stores the low 32 bits zero-extended.
- R5: The full forms accept only register index 1 or 5. The short form (op_short_i = 1) of push accepts only index 1, and the short form of pop-and-check accepts only index 5. There is no short pointer read. Any other combination gives exc_cause_o = 0 (illegal instruction), with no memory request and no pointer change.
- R6: When active_i = 0, every operation completes one cycle after acceptance with no exception, no memory request and no pointer change, whatever its register index or form. A pointer read then writes 0 to its destination.
- R7: A pointer read (op_kind_i = 2) writes the current pointer to destination op_rd_i one cycle after acceptance, with no memory request and regardless of bare_i.
- R8: With bare_i = 1 and priv_i other than 3 (machine), a valid push gives exc_cause_o = 2 (store/AMO access fault) and a valid pop-and-check gives exc_cause_o = 1 (load access fault). In both cases there is no memory request. With priv_i = 3 the operation proceeds normally.
- R9: busy_o is high and op_ready_o is low from acceptance of a memory operation until its response is consumed. While mem_req_ready_i is low, a pending request holds its address and data.
- R10: op_kind_i = 3 is a no-op that only pulses done_o. Every wb_valid_o or exc_valid_o pulse coincides with done_o, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| op_valid_i | input | 1 | Decoded operation present |
| op_ready_o | output | 1 | Unit can accept an operation |
| op_kind_i | input | 2 | 0 push, 1 pop-and-check, 2 pointer read, 3 no-op |
| op_short_i | input | 1 | Operation came from the short encoding |
| op_reg_i | input | 5 | Source / compared register index |
| op_val_i | input | XLEN_MAX | Value of that register |
| op_rd_i | input | 5 | Destination register of pointer read |
| wide_i | input | 1 | 1: 64-bit entries, 0: 32-bit entries |
| active_i | input | 1 | Feature active at current privilege |
| bare_i | input | 1 | Address translation is untranslated (bare) |
| priv_i | input | 2 | Effective privilege, 3 is machine |
| busy_o | output | 1 | Memory operation in flight |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory accepts request |
| mem_req_write_o | output | 1 | 1 store, 0 load |
| mem_req_wide_o | output | 1 | Access size is 64 bits |
| mem_req_addr_o | output | XLEN_MAX | Byte address |
| mem_req_wdata_o | output | XLEN_MAX | Store data |
| mem_rsp_valid_i | input | 1 | Memory response |
| mem_rsp_rdata_i | input | XLEN_MAX | Load data |
| ssp_o | output | XLEN_MAX | Current shadow stack pointer |
| done_o | output | 1 | Operation retired (one-cycle pulse) |
| wb_valid_o | output | 1 | Destination write-back |
| wb_idx_o | output | 5 | Write-back register index |
| wb_data_o | output | XLEN_MAX | Write-back value |
| exc_valid_o | output | 1 | Exception raised |
| exc_cause_o | output | 2 | 0 illegal, 1 load fault, 2 store fault, 3 software check |

## Verification
The bench builds the unit with XLEN_MAX = 64 and RESET_PTR = 0x2000. The 64-bit width makes both entry sizes reachable: 8-byte steps in wide mode and 4-byte steps with low-half comparison in narrow mode. The non-zero reset pointer lets pushes and pops move in both directions without a setup path. Its memory model can hold off the request handshake and delay the response, which keeps the busy window and the held request exposed for several cycles.

// File: rtl/ssu_pkg.sv
package ssu_pkg;

    typedef enum logic [1:0] {
        OP_PUSH   = 2'd0,
        OP_POPCHK = 2'd1,
        OP_RDPTR  = 2'd2,
        OP_NOP    = 2'd3
    } ssu_op_e;

    typedef enum logic [1:0] {
        EXC_ILLEGAL = 2'd0,
        EXC_LD_FLT  = 2'd1,
        EXC_ST_FLT  = 2'd2,
        EXC_SWCHECK = 2'd3
    } ssu_exc_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } ssu_state_e;

    localparam logic [1:0] PRIV_MACHINE = 2'b11;
    localparam logic [4:0] LINK_A       = 5'd1;
    localparam logic [4:0] LINK_B       = 5'd5;

endpackage

// File: rtl/ssu_opcheck.sv
module ssu_opcheck
    import ssu_pkg::*;
(
    input  ssu_op_e    op_i,
    input  logic       short_i,
    input  logic [4:0] reg_i,
    input  logic       active_i,
    input  logic       bare_i,
    input  logic [1:0] priv_i,
    output logic       mop_o,
    output logic       illegal_o,
    output logic       fault_o,
    output ssu_exc_e   fault_cause_o,
    output logic       mem_o
);

    logic is_mem;
    logic full_ok;
    logic short_ok;
    logic reg_ok;
    logic blocked;

    always_comb begin
        is_mem   = (op_i == OP_PUSH) || (op_i == OP_POPCHK);
        full_ok  = (reg_i == LINK_A) || (reg_i == LINK_B);
        short_ok = ((op_i == OP_PUSH) && (reg_i == LINK_A)) ||
                   ((op_i == OP_POPCHK) && (reg_i == LINK_B));
        if (op_i == OP_RDPTR) begin
            reg_ok = !short_i;
        end else if (short_i) begin
            reg_ok = short_ok;
        end else begin
            reg_ok = full_ok;
        end
        blocked       = bare_i && (priv_i != PRIV_MACHINE);
        mop_o         = (op_i == OP_NOP) || !active_i;
        illegal_o     = !mop_o && !reg_ok;
        fault_o       = !mop_o && reg_ok && is_mem && blocked;
        fault_cause_o = (op_i == OP_PUSH) ? EXC_ST_FLT : EXC_LD_FLT;
        mem_o         = !mop_o && reg_ok && is_mem && !blocked;
    end

endmodule

// File: rtl/ssu_ptr_step.sv
module ssu_ptr_step #(
    parameter int XLEN_MAX = 64
) (
    input  logic [XLEN_MAX-1:0] ptr_i,
    input  logic                wide_i,
    output logic [XLEN_MAX-1:0] ptr_dn_o,
    output logic [XLEN_MAX-1:0] ptr_up_o
);

    localparam int W = XLEN_MAX;

    logic [W-1:0] step;

    generate
        if (W > 32) begin : g_two_sizes
            assign step = wide_i ? W'(8) : W'(4);
        end else begin : g_one_size
            logic unused_wide;
            assign unused_wide = wide_i;
            assign step        = W'(4);
        end
    endgenerate

    assign ptr_dn_o = ptr_i - step;
    assign ptr_up_o = ptr_i + step;

endmodule

// File: rtl/shadow_stack_unit.sv
module shadow_stack_unit
    import ssu_pkg::*;
#(
    parameter int                  XLEN_MAX  = 64,
    parameter logic [XLEN_MAX-1:0] RESET_PTR = XLEN_MAX'(32'h0000_8000)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                op_valid_i,
    output logic                op_ready_o,
    input  logic [1:0]          op_kind_i,
    input  logic                op_short_i,
    input  logic [4:0]          op_reg_i,
    input  logic [XLEN_MAX-1:0] op_val_i,
    input  logic [4:0]          op_rd_i,
    input  logic                wide_i,
    input  logic                active_i,
    input  logic                bare_i,
    input  logic [1:0]          priv_i,
    output logic                busy_o,
    output logic                mem_req_valid_o,
    input  logic                mem_req_ready_i,
    output logic                mem_req_write_o,
    output logic                mem_req_wide_o,
    output logic [XLEN_MAX-1:0] mem_req_addr_o,
    output logic [XLEN_MAX-1:0] mem_req_wdata_o,
    input  logic                mem_rsp_valid_i,
    input  logic [XLEN_MAX-1:0] mem_rsp_rdata_i,
    output logic [XLEN_MAX-1:0] ssp_o,
    output logic                done_o,
    output logic                wb_valid_o,
    output logic [4:0]          wb_idx_o,
    output logic [XLEN_MAX-1:0] wb_data_o,
    output logic                exc_valid_o,
    output logic [1:0]          exc_cause_o
);

    localparam int           W       = XLEN_MAX;
    localparam logic [W-1:0] LO_MASK = W'(32'hFFFF_FFFF);

    typedef struct packed {
        ssu_state_e   st;
        logic [W-1:0] ssp;
        logic         push;
        logic         wide;
        logic [W-1:0] link;
        logic [W-1:0] addr;
        logic [W-1:0] wdata;
        logic         done;
        logic         wb_v;
        logic [4:0]   wb_idx;
        logic [W-1:0] wb_data;
        logic         exc_v;
        ssu_exc_e     exc;
    } regs_t;

    regs_t r_d, r_q;

    ssu_op_e      op_k;
    logic         wide_eff;
    logic [W-1:0] mask_in;
    logic [W-1:0] mask_q;
    logic         chk_mop;
    logic         chk_illegal;
    logic         chk_fault;
    ssu_exc_e     chk_cause;
    logic         chk_mem;
    logic         step_wide;
    logic [W-1:0] ptr_dn;
    logic [W-1:0] ptr_up;
    logic         entry_match;

    assign op_k     = ssu_op_e'(op_kind_i);
    assign wide_eff = wide_i && (W > 32);
    assign mask_in  = wide_eff ? '1 : LO_MASK;
    assign mask_q   = r_q.wide ? '1 : LO_MASK;
    assign step_wide = (r_q.st == ST_IDLE) ? wide_eff : r_q.wide;
    assign entry_match = ((mem_rsp_rdata_i ^ r_q.link) & mask_q) == '0;

    ssu_opcheck u_opcheck (
        .op_i          (op_k),
        .short_i       (op_short_i),
        .reg_i         (op_reg_i),
        .active_i      (active_i),
        .bare_i        (bare_i),
        .priv_i        (priv_i),
        .mop_o         (chk_mop),
        .illegal_o     (chk_illegal),
        .fault_o       (chk_fault),
        .fault_cause_o (chk_cause),
        .mem_o         (chk_mem)
    );

    ssu_ptr_step #(
        .XLEN_MAX (W)
    ) u_ptr_step (
        .ptr_i    (r_q.ssp),
        .wide_i   (step_wide),
        .ptr_dn_o (ptr_dn),
        .ptr_up_o (ptr_up)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.wb_v  = 1'b0;
        r_d.exc_v = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (op_valid_i) begin
                    r_d.wb_idx = op_rd_i;
                    if (chk_mop) begin
                        r_d.done = 1'b1;
                        if (op_k == OP_RDPTR) begin
                            r_d.wb_v    = 1'b1;
                            r_d.wb_data = '0;
                        end
                    end else if (chk_illegal) begin
                        r_d.done  = 1'b1;
                        r_d.exc_v = 1'b1;
                        r_d.exc   = EXC_ILLEGAL;
                    end else if (op_k == OP_RDPTR) begin
                        r_d.done    = 1'b1;
                        r_d.wb_v    = 1'b1;
                        r_d.wb_data = r_q.ssp;
                    end else if (chk_fault) begin
                        r_d.done  = 1'b1;
                        r_d.exc_v = 1'b1;
                        r_d.exc   = chk_cause;
                    end else if (chk_mem) begin
                        r_d.st    = ST_REQ;
                        r_d.push  = (op_k == OP_PUSH);
                        r_d.wide  = wide_eff;
                        r_d.link  = op_val_i & mask_in;
                        r_d.wdata = op_val_i & mask_in;
                        r_d.addr  = (op_k == OP_PUSH) ? ptr_dn : r_q.ssp;
                    end
                end
            end
            ST_REQ: begin
                if (mem_req_ready_i) begin
                    r_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid_i) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    if (r_q.push) begin
                        r_d.ssp = r_q.addr;
                    end else if (entry_match) begin
                        r_d.ssp = ptr_up;
                    end else begin
                        r_d.exc_v = 1'b1;
                        r_d.exc   = EXC_SWCHECK;
                    end
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q     <= '0;
            r_q.ssp <= RESET_PTR;
        end else begin
            r_q <= r_d;
        end
    end

    assign op_ready_o      = (r_q.st == ST_IDLE);
    assign busy_o          = (r_q.st != ST_IDLE);
    assign mem_req_valid_o = (r_q.st == ST_REQ);
    assign mem_req_write_o = r_q.push;
    assign mem_req_wide_o  = r_q.wide;
    assign mem_req_addr_o  = r_q.addr;
    assign mem_req_wdata_o = r_q.wdata;
    assign ssp_o           = r_q.ssp;
    assign done_o          = r_q.done;
    assign wb_valid_o      = r_q.wb_v;
    assign wb_idx_o        = r_q.wb_idx;
    assign wb_data_o       = r_q.wb_data;
    assign exc_valid_o     = r_q.exc_v;
    assign exc_cause_o     = r_q.exc;

    // R2: a completed push leaves the pointer exactly one entry lower
    a_r2_push_lowers: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == ST_WAIT && mem_rsp_valid_i && r_q.push)
        |=> (ssp_o == $past(ssp_o) - ($past(r_q.wide) ? W'(8) : W'(4))));

    // R3: a pop that retires without exception raised the pointer one entry
    a_r3_pop_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == ST_WAIT && mem_rsp_valid_i && !r_q.push)
        |=> (exc_valid_o || (ssp_o == $past(ssp_o) + ($past(r_q.wide) ? W'(8) : W'(4)))));

    // R4: any exception leaves the pointer unchanged
    a_r4_exc_keeps_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exc_valid_o |-> (ssp_o == $past(ssp_o)));

    // R6: inactive operations make no request and stay idle
    a_r6_inactive_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_valid_i && op_ready_o && !active_i)
        |=> (!mem_req_valid_o && !busy_o && $stable(ssp_o)));

    // R8: refused accesses under bare addressing below machine level
    a_r8_bare_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_valid_i && op_ready_o && active_i && bare_i && priv_i != PRIV_MACHINE)
        |=> !mem_req_valid_o);

    // R9: a stalled request holds its contents
    a_r9_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_valid_o && !mem_req_ready_i)
        |=> (mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_wdata_o)));

    // R1: the pointer only moves when a memory response is consumed
    a_r1_ptr_moves_on_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ssp_o != $past(ssp_o)) |-> $past(mem_rsp_valid_i));

    // R10: results appear only with done and never both kinds at once
    a_r10_result_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wb_valid_o || exc_valid_o) |-> (done_o && $onehot0({wb_valid_o, exc_valid_o})));

endmodule

// File: tb/shadow_stack_unit_tb_top.sv
`timescale 1ns/1ps
module shadow_stack_unit_tb_top;

    localparam int          W   = 64;
    localparam logic [63:0] RST = 64'h2000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic          op_ready;
    logic [1:0]    op_kind = '0;
    logic          op_short = 1'b0;
    logic [4:0]    op_reg = '0;
    logic [W-1:0]  op_val = '0;
    logic [4:0]    op_rd = '0;
    logic          wide = 1'b1;
    logic          active = 1'b1;
    logic          bare = 1'b0;
    logic [1:0]    priv = 2'd0;
    logic          busy;
    logic          req_valid;
    logic          req_ready = 1'b0;
    logic          req_write;
    logic          req_wide;
    logic [W-1:0]  req_addr;
    logic [W-1:0]  req_wdata;
    logic          rsp_valid = 1'b0;
    logic [W-1:0]  rsp_rdata = '0;
    logic [W-1:0]  ssp;
    logic          done;
    logic          wb_valid;
    logic [4:0]    wb_idx;
    logic [W-1:0]  wb_data;
    logic          exc_valid;
    logic [1:0]    exc_cause;

    always #2 clk = ~clk;

    shadow_stack_unit #(.XLEN_MAX(W), .RESET_PTR(RST)) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .op_valid_i(op_valid), .op_ready_o(op_ready), .op_kind_i(op_kind),
        .op_short_i(op_short), .op_reg_i(op_reg), .op_val_i(op_val), .op_rd_i(op_rd),
        .wide_i(wide), .active_i(active), .bare_i(bare), .priv_i(priv),
        .busy_o(busy), .mem_req_valid_o(req_valid), .mem_req_ready_i(req_ready),
        .mem_req_write_o(req_write), .mem_req_wide_o(req_wide),
        .mem_req_addr_o(req_addr), .mem_req_wdata_o(req_wdata),
        .mem_rsp_valid_i(rsp_valid), .mem_rsp_rdata_i(rsp_rdata),
        .ssp_o(ssp), .done_o(done), .wb_valid_o(wb_valid), .wb_idx_o(wb_idx),
        .wb_data_o(wb_data), .exc_valid_o(exc_valid), .exc_cause_o(exc_cause)
    );

    typedef struct {
        logic        wb_v;
        logic [4:0]  wb_i;
        logic [63:0] wb_d;
        logic        exc_v;
        logic [1:0]  exc_c;
        logic [63:0] ssp;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    int          n_tests = 0;
    int          n_fail = 0;
    bit          finished = 0;
    logic [63:0] mem [logic [63:0]];
    int          req_count = 0;
    logic [63:0] last_addr = '0;
    logic        last_write = 1'b0;
    int          cfg_rdy = 0;
    int          cfg_lat = 0;
    int          busy_cnt = 0;

    function automatic void check(input bit ok, input string tag,
                                  input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endfunction

    // memory responder
    initial begin : responder
        bit pending = 0;
        int lat = 0;
        int wcnt = 0;
        forever begin
            @(negedge clk);
            rsp_valid <= 1'b0;
            req_ready <= 1'b0;
            if (pending) begin
                if (lat == 0) begin
                    rsp_valid <= 1'b1;
                    pending = 0;
                end else begin
                    lat--;
                end
            end else if (req_valid) begin
                if (wcnt < cfg_rdy) begin
                    wcnt++;
                end else begin
                    wcnt = 0;
                    req_ready <= 1'b1;
                    pending = 1;
                    lat = cfg_lat;
                    req_count++;
                    last_addr = req_addr;
                    last_write = req_write;
                    if (req_write) begin
                        mem[req_addr] = req_wdata;
                    end else begin
                        rsp_rdata <= mem.exists(req_addr) ? mem[req_addr] : 64'h0;
                    end
                end
            end
        end
    end

    // monitor / scoreboard
    initial begin : monitor
        forever begin
            @(negedge clk);
            if (busy) busy_cnt++;
            if (busy && op_ready) check(1'b0, "R9 ready while busy", 64'(op_ready), 64'h0);
            if (done) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R10 unexpected done", 64'h1, 64'h0);
                end else begin
                    exp_t e;
                    bit ok;
                    e = sb_q.pop_front();
                    ok = (wb_valid == e.wb_v) && (exc_valid == e.exc_v) && (ssp == e.ssp);
                    if (e.wb_v) ok = ok && (wb_idx == e.wb_i) && (wb_data == e.wb_d);
                    if (e.exc_v) ok = ok && (exc_cause == e.exc_c);
                    check(ok, $sformatf("%s wb=%0b/%0d/%h exc=%0b/%0d", e.tag, wb_valid,
                          wb_idx, wb_data, exc_valid, exc_cause), ssp, e.ssp);
                end
            end
        end
    end

    task automatic issue(input logic [1:0] k, input logic s, input logic [4:0] r,
                         input logic [63:0] v, input logic [4:0] rd,
                         input logic ewb, input logic [63:0] ewd,
                         input logic eexc, input logic [1:0] ec,
                         input logic [63:0] essp, input string tag);
        exp_t e;
        e.wb_v = ewb; e.wb_i = rd; e.wb_d = ewd;
        e.exc_v = eexc; e.exc_c = ec; e.ssp = essp; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        while (!op_ready) @(negedge clk);
        op_kind = k; op_short = s; op_reg = r; op_val = v; op_rd = rd;
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        wait (sb_q.size() == 0);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    localparam logic [63:0] VA = 64'h1111_2222_3333_4444;
    localparam logic [63:0] VB = 64'h5555_6666_7777_8888;
    localparam logic [63:0] VC = 64'h0BAD_F00D_0000_1234;
    localparam logic [63:0] VD = 64'hCAFE_0000_BEEF_0001;

    initial begin : stim
        int rc;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(ssp == RST, "R1 reset pointer", ssp, RST);
        check(!busy && !req_valid, "R1 reset idle", {62'h0, busy, req_valid}, 64'h0);
        check(!done && !wb_valid && !exc_valid, "R1 reset no pulse",
              {61'h0, done, wb_valid, exc_valid}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ssp == RST && !busy, "R1 after release", ssp, RST);

        // R2 push wide
        issue(2'd0, 0, 5'd1, VA, 5'd0, 0, 0, 0, 0, 64'h1FF8, "R2 push x1");
        check(last_addr == 64'h1FF8 && last_write, "R2 push address", last_addr, 64'h1FF8);
        check(mem[64'h1FF8] == VA, "R2 push data", mem[64'h1FF8], VA);

        // R9 push with stalled handshake and slow response
        cfg_rdy = 2; cfg_lat = 3; busy_cnt = 0;
        issue(2'd0, 0, 5'd5, VB, 5'd0, 0, 0, 0, 0, 64'h1FF0, "R9 stalled push x5");
        check(busy_cnt >= 5, "R9 busy window", 64'(busy_cnt), 64'd5);
        check(mem[64'h1FF0] == VB, "R2 stalled push data", mem[64'h1FF0], VB);
        cfg_rdy = 0; cfg_lat = 0;

        // R7 pointer read
        rc = req_count;
        issue(2'd2, 0, 5'd0, 0, 5'd10, 1, 64'h1FF0, 0, 0, 64'h1FF0, "R7 read pointer");
        check(req_count == rc, "R7 no memory access", 64'(req_count), 64'(rc));

        // R3 pop-check match
        issue(2'd1, 0, 5'd5, VB, 5'd0, 0, 0, 0, 0, 64'h1FF8, "R3 pop x5 match");
        check(last_addr == 64'h1FF0 && !last_write, "R3 pop address", last_addr, 64'h1FF0);

        // R4 mismatch
        issue(2'd1, 0, 5'd1, VA ^ 64'h1, 5'd0, 0, 0, 1, 2'd3, 64'h1FF8, "R4 pop mismatch");
        issue(2'd1, 0, 5'd1, VA, 5'd0, 0, 0, 0, 0, 64'h2000, "R3 pop x1 match");

        // R5 register restrictions
        rc = req_count;
        issue(2'd0, 0, 5'd2, VA, 5'd0, 0, 0, 1, 2'd0, 64'h2000, "R5 push x2 illegal");
        issue(2'd0, 1, 5'd5, VA, 5'd0, 0, 0, 1, 2'd0, 64'h2000, "R5 short push x5 illegal");
        issue(2'd2, 1, 5'd0, 0, 5'd3, 0, 0, 1, 2'd0, 64'h2000, "R5 short read illegal");
        issue(2'd1, 0, 5'd7, VA, 5'd0, 0, 0, 1, 2'd0, 64'h2000, "R5 pop x7 illegal");
        check(req_count == rc, "R5 no memory access", 64'(req_count), 64'(rc));
        issue(2'd0, 1, 5'd1, VC, 5'd0, 0, 0, 0, 0, 64'h1FF8, "R5 short push x1");
        issue(2'd1, 1, 5'd1, VC, 5'd0, 0, 0, 1, 2'd0, 64'h1FF8, "R5 short pop x1 illegal");
        issue(2'd1, 1, 5'd5, VC, 5'd0, 0, 0, 0, 0, 64'h2000, "R5 short pop x5");

        // R6 inactive fallback
        active = 1'b0;
        rc = req_count;
        issue(2'd0, 0, 5'd1, VA, 5'd0, 0, 0, 0, 0, 64'h2000, "R6 inactive push");
        issue(2'd1, 0, 5'd5, VA, 5'd0, 0, 0, 0, 0, 64'h2000, "R6 inactive pop");
        issue(2'd0, 1, 5'd5, VA, 5'd0, 0, 0, 0, 0, 64'h2000, "R6 inactive short x5");
        issue(2'd2, 0, 5'd0, 0, 5'd7, 1, 64'h0, 0, 0, 64'h2000, "R6 inactive read zero");
        check(req_count == rc, "R6 no memory access", 64'(req_count), 64'(rc));
        active = 1'b1;

        // R8 bare addressing
        bare = 1'b1; priv = 2'd1;
        rc = req_count;
        issue(2'd0, 0, 5'd1, VD, 5'd0, 0, 0, 1, 2'd2, 64'h2000, "R8 bare push fault");
        issue(2'd1, 0, 5'd5, VD, 5'd0, 0, 0, 1, 2'd1, 64'h2000, "R8 bare pop fault");
        issue(2'd2, 0, 5'd0, 0, 5'd9, 1, 64'h2000, 0, 0, 64'h2000, "R7 read under bare");
        check(req_count == rc, "R8 no memory access", 64'(req_count), 64'(rc));
        priv = 2'd3;
        issue(2'd0, 0, 5'd1, VD, 5'd0, 0, 0, 0, 0, 64'h1FF8, "R8 machine push");
        issue(2'd1, 0, 5'd1, VD, 5'd0, 0, 0, 0, 0, 64'h2000, "R8 machine pop");
        bare = 1'b0; priv = 2'd0;

        // R4 narrow entries
        wide = 1'b0;
        issue(2'd0, 0, 5'd1, 64'hDEAD_BEEF_1234_5678, 5'd0, 0, 0, 0, 0, 64'h1FFC,
              "R2 narrow push");
        check(mem[64'h1FFC] == 64'h0000_0000_1234_5678, "R4 narrow store zero-extended",
              mem[64'h1FFC], 64'h0000_0000_1234_5678);
        issue(2'd1, 0, 5'd1, 64'hFFFF_FFFF_1234_5678, 5'd0, 0, 0, 0, 0, 64'h2000,
              "R4 narrow pop low half match");
        issue(2'd0, 0, 5'd5, 64'h0000_0000_0000_00AA, 5'd0, 0, 0, 0, 0, 64'h1FFC,
              "R2 narrow push x5");
        issue(2'd1, 0, 5'd5, 64'h0000_0000_0000_00AB, 5'd0, 0, 0, 1, 2'd3, 64'h1FFC,
              "R4 narrow pop mismatch");
        wide = 1'b1;

        // R10 no-op
        rc = req_count;
        issue(2'd3, 0, 5'd1, VA, 5'd4, 0, 0, 0, 0, 64'h1FFC, "R10 no-op");
        check(req_count == rc && !busy, "R10 no-op quiet", 64'(req_count), 64'(rc));

        repeat (4) @(negedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule